// File: doc/BRIEF.md
# Interlace-Capable Raster Timing Generator

This block produces the timing skeleton of a video raster from a set of programmed mode values. From a sample counter and a line counter it derives horizontal and vertical sync pulses of selectable polarity, a data-enable, a field flag and a one-clock start-of-frame marker. It also drives a video standard code and a divided reference tick. Both progressive and interlaced modes are supported. In interlaced operation each of the two fields has its own active height and its own vertical porch, sync and blanking values. Pixel data is not carried.

The mode inputs are copied into shadow registers, so software can rewrite them at any time. A change takes effect only at the next frame boundary. The generator runs while both the run input and the mode-valid input are high. When either drops, the outputs fall back to an idle pattern within two clocks. A restart always begins at raster position zero.

Top module: `vtg_raster_gen`

## Requirements
- R1: While reset is asserted, every output is 0. While the generator is not running, `de_o`, `field_o`, `sof_o` and `div_tick_o` are 0, and each sync output sits at its inactive level, which is the inverse of its polarity bit.
- R2: A line lasts `act_w_i + h_blank_i` clocks, with one sample per clock. Sample s is active for s < `act_w_i`. The horizontal sync is asserted for samples `act_w_i + h_fp_i` up to, but not including, `act_w_i + h_fp_i + h_sw_i`. `de_o` is 1 only when both the sample and the line are active.
- R3: In progressive mode (`ilace_i` = 0), a frame has `act_h0_i + v_blank_i` lines, of which lines below `act_h0_i` are active. The vertical sync is asserted for the whole of lines `act_h0_i + v_fp_i` up to, but not including, that value plus `v_sw_i`.
- R4: In interlaced mode (`ilace_i` = 1), field 0 comes first and uses `act_h0_i` with the field-0 values `f0_v_fp_i`, `f0_v_sw_i` and `f0_v_blank_i`. Field 1 follows, using `act_h1_i`, `v_fp_i`, `v_sw_i` and `v_blank_i`. Each field is laid out as active lines, then front porch, then sync, then the rest of its blanking.
- R5: A polarity bit of 1 makes its sync output active-high. A polarity bit of 0 makes it active-low.
- R6: In interlaced mode, `field_o` is 1 on line numbers from `fld_rise_i` up to, but not including, `fld_fall_i`, counted from the start of the frame. When rise is greater than fall, the range wraps through the end of the frame. In progressive mode `field_o` is 0.
- R7: `sof_o` is a single-clock pulse that fires once per frame. It marks sample `sof_pos_i[15:2]` on the line `(vs0 + sof_line_i) mod frame_lines`, where vs0 is the first line of the field-0 vertical sync (`act_h0_i` plus the front porch that applies to field 0).
- R8: The subsample field `sof_pos_i[1:0]` delays the start-of-frame pulse by that many clocks, from 0 to 3. The delay carries across line and frame ends.
- R9: Counted from the start, `div_tick_o` pulses on the last clock of every `div_len_i` clocks. A length of 0 or 1 makes it pulse on every clock.
- R10: `std_o` carries the `std_i` value that is in force for the frame shown.
- R11: Mode values written while the generator is running take effect at the first sample of the next frame. The current frame finishes with the old values.
- R12: The outputs for raster position 0 appear after the second rising edge at which both run and valid are sampled high. After run or valid is sampled low, one further position is shown, and from the next clock on the outputs are idle.
- R13: With `run_i` high and `mode_valid_i` low, the generator stays idle. Raising `mode_valid_i` then starts it from position 0, and dropping `mode_valid_i` stops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Run request |
| mode_valid_i | input | 1 | Mode values are valid |
| ilace_i | input | 1 | 1 = interlaced, 0 = progressive |
| act_w_i | input | HW | Active samples per line |
| act_h0_i | input | VW | Active lines, field 0 or progressive |
| act_h1_i | input | VW | Active lines, field 1 |
| h_fp_i | input | HW | Horizontal front porch in samples |
| h_sw_i | input | HW | Horizontal sync width in samples |
| h_blank_i | input | HW | Horizontal blanking in samples |
| v_fp_i | input | VW | Vertical front porch in lines (progressive or field 1) |
| v_sw_i | input | VW | Vertical sync width in lines (progressive or field 1) |
| v_blank_i | input | VW | Vertical blanking in lines (progressive or field 1) |
| f0_v_fp_i | input | VW | Field-0 vertical front porch |
| f0_v_sw_i | input | VW | Field-0 vertical sync width |
| f0_v_blank_i | input | VW | Field-0 vertical blanking |
| fld_rise_i | input | VW | Line on which the field flag rises |
| fld_fall_i | input | VW | Line on which the field flag falls |
| hs_pol_i | input | 1 | Horizontal sync polarity |
| vs_pol_i | input | 1 | Vertical sync polarity |
| std_i | input | STDW | Video standard code |
| sof_pos_i | input | 16 | Start-of-frame sample [15:2] and subsample [1:0] |
| sof_line_i | input | 13 | Start-of-frame line, counted from the field-0 vsync start |
| div_len_i | input | 14 | Divider length in clocks |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| field_o | output | 1 | Field flag |
| sof_o | output | 1 | Start-of-frame pulse |
| std_o | output | STDW | Video standard code |
| div_tick_o | output | 1 | Divided reference tick |

## Verification
The bench aims at several corner cases, and each has a visible failure mode:
- **Start-of-frame on the last sample of a line, with the largest subsample delay.** A design that reset its delay pipeline at line end would drop the pulse, and one that decoded the delay wrongly would shift it.
- **Field-flag range that wraps past the end of the frame** (rise line greater than fall line). A plain range comparison would never raise the flag.
- **Mode values rewritten in mid-frame.** A generator that loaded them at once would bend the current frame's geometry.
- **Stopping through either run or valid, then restarting.** A design that resumed its counters, or left the divider phase running, would show the wrong raster position or tick timing.
- **A divider length of one.** An off-by-one in the wrap compare would skip every second tick.

// File: rtl/vtg_pkg.sv
// Shared constants and helpers for the raster timing generator.
// Assumes: nothing beyond IEEE 1800-2017.
package vtg_pkg;
    localparam int SOF_POS_W  = 16;   // sample [15:2] and subsample [1:0]
    localparam int SOF_SUB_W  = 2;
    localparam int SOF_LINE_W = 13;
    localparam int DIV_W      = 14;

    // True when p lies in [lo, hi), wrapping through zero when lo > hi.
    function automatic logic wrap_span(input int unsigned p,
                                       input int unsigned lo,
                                       input int unsigned hi);
        if (lo <= hi) return (p >= lo) && (p < hi);
        return (p >= lo) || (p < hi);
    endfunction
endpackage

// File: rtl/vtg_hcount.sv
// Sample counter of one line, with the active and sync regions decoded from it.
// Assumes: act_w + blank >= 1 and fp + sw <= blank. The mode values stay
// constant while clr is low, except at a frame end.
module vtg_hcount #(
    parameter int HW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [HW-1:0] act_w,
    input  logic [HW-1:0] fp,
    input  logic [HW-1:0] sw,
    input  logic [HW-1:0] blank,
    output logic [HW:0]   h,
    output logic          line_end,
    output logic          h_act,
    output logic          h_sync
);
    logic [HW:0]   tot;
    logic [HW+1:0] s_lo, s_hi;

    // Line length and the sync window bounds.
    always_comb begin
        tot  = {1'b0, act_w} + {1'b0, blank};
        s_lo = {2'b00, act_w} + {2'b00, fp};
        s_hi = s_lo + {2'b00, sw};
    end

    // Region decode for the current sample.
    always_comb begin
        line_end = (h >= tot - 1'b1);
        h_act    = (h < {1'b0, act_w});
        h_sync   = ({1'b0, h} >= s_lo) && ({1'b0, h} < s_hi);
    end

    // Sample counter, wrapping at the end of the line.
    always_ff @(posedge clk) begin
        if (!rst_n)        h <= '0;
        else if (clr)      h <= '0;
        else if (line_end) h <= '0;
        else               h <= h + 1'b1;
    end

    // R2
    h_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (h < tot));
endmodule

// File: rtl/vtg_vcount.sv
// Line counter of one frame, with the per-field vertical layout decoded from it.
// Interlaced frames put field 0 first and field 1 after it; progressive frames
// use the field-0 height with the common vertical values.
// Assumes: front porch + sync <= blanking in each field.
module vtg_vcount #(
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic          ilace,
    input  logic [VW-1:0] a0,
    input  logic [VW-1:0] a1,
    input  logic [VW-1:0] fp,
    input  logic [VW-1:0] sw,
    input  logic [VW-1:0] blank,
    input  logic [VW-1:0] f0_fp,
    input  logic [VW-1:0] f0_sw,
    input  logic [VW-1:0] f0_blank,
    input  logic [VW-1:0] f_rise,
    input  logic [VW-1:0] f_fall,
    output logic [VW+2:0] v,
    output logic [VW+2:0] total,
    output logic [VW+2:0] vs0,
    output logic          last_line,
    output logic          v_act,
    output logic          v_sync,
    output logic          field
);
    localparam int VX = VW + 3;

    logic [VX-1:0] end0, end1a, vs0_end, vs1, vs1_end;
    logic [VW-1:0] s0_fp, s0_sw, s0_blank;

    function automatic logic [VX-1:0] ext(input logic [VW-1:0] a);
        return {3'b000, a};
    endfunction

    // Pick the vertical values of the first field, then lay out the frame.
    always_comb begin
        s0_fp    = ilace ? f0_fp    : fp;
        s0_sw    = ilace ? f0_sw    : sw;
        s0_blank = ilace ? f0_blank : blank;
        end0     = ext(a0) + ext(s0_blank);
        end1a    = end0 + ext(a1);
        total    = ilace ? (end1a + ext(blank)) : end0;
        vs0      = ext(a0) + ext(s0_fp);
        vs0_end  = vs0 + ext(s0_sw);
        vs1      = end1a + ext(fp);
        vs1_end  = vs1 + ext(sw);
    end

    // Region decode for the current line.
    always_comb begin
        last_line = (v >= total - 1'b1);
        v_act     = (v < ext(a0)) || (ilace && (v >= end0) && (v < end1a));
        v_sync    = ((v >= vs0) && (v < vs0_end)) ||
                    (ilace && (v >= vs1) && (v < vs1_end));
        field     = ilace && vtg_pkg::wrap_span(32'(v), 32'(f_rise), 32'(f_fall));
    end

    // Line counter, advanced at each line end and wrapped at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)        v <= '0;
        else if (clr)      v <= '0;
        else if (adv)      v <= last_line ? '0 : v + 1'b1;
    end

    // R3
    v_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !adv) |=> $stable(v));
endmodule

// File: rtl/vtg_sof.sv
// Start-of-frame marker: compares the raster position against the programmed
// sample and line, then delays the hit by the subsample count (0..3 clocks).
// Assumes: sample < line length and line offset < frame lines.
module vtg_sof
    import vtg_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic [HW:0]           h,
    input  logic [VW+2:0]         v,
    input  logic [VW+2:0]         total,
    input  logic [VW+2:0]         vs0,
    input  logic [SOF_POS_W-1:0]  pos,
    input  logic [SOF_LINE_W-1:0] line,
    output logic                  sof
);
    localparam int VX   = VW + 3;
    localparam int TW   = ((VX > SOF_LINE_W) ? VX : SOF_LINE_W) + 1;
    localparam int NDLY = 1 << SOF_SUB_W;

    logic [TW-1:0]   tsum, tgt;
    logic            hit;
    logic [NDLY-1:0] pipe;

    // Target line relative to the field-0 vsync start, folded into the frame.
    always_comb begin
        tsum = TW'(vs0) + TW'(line);
        tgt  = (tsum >= TW'(total)) ? (tsum - TW'(total)) : tsum;
        hit  = (SOF_POS_W'(h) == {2'b00, pos[SOF_POS_W-1:SOF_SUB_W]}) &&
               (TW'(v) == tgt);
    end

    // Delay line of hits, one stage per subsample step.
    for (genvar k = 0; k < NDLY; k++) begin : g_stage
        if (k == 0) begin : g_head
            // First stage registers the raw hit.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) pipe[0] <= 1'b0;
                else               pipe[0] <= hit;
            end
        end else begin : g_tail
            // Later stages shift the hit by one clock.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) pipe[k] <= 1'b0;
                else               pipe[k] <= pipe[k-1];
            end
        end
    end

    assign sof = pipe[pos[SOF_SUB_W-1:0]];

    // R7
    sof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !sof);
endmodule

// File: rtl/vtg_divider.sv
// Free-running divider of the video clock: flags the last clock of each period.
// Assumes: a length of 0 behaves as 1.
module vtg_divider #(
    parameter int DW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [DW-1:0] len,
    output logic          tick_now
);
    logic [DW-1:0] cnt, lim;

    // Last count of the period.
    always_comb begin
        lim      = (len == '0) ? '0 : len - 1'b1;
        tick_now = (cnt >= lim);
    end

    // Period counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (tick_now) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    // R9
    div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && tick_now) |=> (cnt == '0));
endmodule

// File: rtl/vtg_raster_gen.sv
// Programmable raster timing generator. The mode inputs are shadowed and
// reloaded only while idle or on the last sample of a frame. All outputs are
// registered and lag the counters by one clock.
// Assumes: mode values within the limits stated in the module headers below.
module vtg_raster_gen
    import vtg_pkg::*;
#(
    parameter int HW   = 12,
    parameter int VW   = 11,
    parameter int STDW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_i,
    input  logic                  mode_valid_i,
    input  logic                  ilace_i,
    input  logic [HW-1:0]         act_w_i,
    input  logic [VW-1:0]         act_h0_i,
    input  logic [VW-1:0]         act_h1_i,
    input  logic [HW-1:0]         h_fp_i,
    input  logic [HW-1:0]         h_sw_i,
    input  logic [HW-1:0]         h_blank_i,
    input  logic [VW-1:0]         v_fp_i,
    input  logic [VW-1:0]         v_sw_i,
    input  logic [VW-1:0]         v_blank_i,
    input  logic [VW-1:0]         f0_v_fp_i,
    input  logic [VW-1:0]         f0_v_sw_i,
    input  logic [VW-1:0]         f0_v_blank_i,
    input  logic [VW-1:0]         fld_rise_i,
    input  logic [VW-1:0]         fld_fall_i,
    input  logic                  hs_pol_i,
    input  logic                  vs_pol_i,
    input  logic [STDW-1:0]       std_i,
    input  logic [SOF_POS_W-1:0]  sof_pos_i,
    input  logic [SOF_LINE_W-1:0] sof_line_i,
    input  logic [DIV_W-1:0]      div_len_i,
    output logic                  hsync_o,
    output logic                  vsync_o,
    output logic                  de_o,
    output logic                  field_o,
    output logic                  sof_o,
    output logic [STDW-1:0]       std_o,
    output logic                  div_tick_o
);
    localparam int HX = HW + 1;
    localparam int VX = VW + 3;

    logic running, clr, load;
    logic sh_ilace, sh_hpol, sh_vpol;
    logic [HW-1:0] sh_aw, sh_hfp, sh_hsw, sh_hbl;
    logic [VW-1:0] sh_ah0, sh_ah1, sh_vfp, sh_vsw, sh_vbl, sh_f0fp, sh_f0sw, sh_f0bl;
    logic [VW-1:0] sh_frise, sh_ffall;
    logic [STDW-1:0] sh_std;
    logic [SOF_POS_W-1:0]  sh_spos;
    logic [SOF_LINE_W-1:0] sh_sline;
    logic [DIV_W-1:0]      sh_div;

    logic [HX-1:0] h;
    logic [VX-1:0] v, v_total, v_vs0;
    logic line_end, h_act, h_sync, last_line, v_act, v_sync, fld, tick_now, sof_w;
    logic hs_q, vs_q, de_q, fld_q, tick_q;
    logic [STDW-1:0] std_q;

    // Run state follows the run and valid inputs one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) running <= 1'b0;
        else        running <= run_i & mode_valid_i;
    end

    assign clr  = ~running;
    assign load = ~running | (line_end & last_line);

    // Shadow copy of the mode, refreshed while idle or at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_ilace <= 1'b0; sh_hpol <= 1'b0; sh_vpol <= 1'b0;
            sh_aw <= '0; sh_hfp <= '0; sh_hsw <= '0; sh_hbl <= '0;
            sh_ah0 <= '0; sh_ah1 <= '0; sh_vfp <= '0; sh_vsw <= '0; sh_vbl <= '0;
            sh_f0fp <= '0; sh_f0sw <= '0; sh_f0bl <= '0;
            sh_frise <= '0; sh_ffall <= '0; sh_std <= '0;
            sh_spos <= '0; sh_sline <= '0; sh_div <= '0;
        end else if (load) begin
            sh_ilace <= ilace_i; sh_hpol <= hs_pol_i; sh_vpol <= vs_pol_i;
            sh_aw <= act_w_i; sh_hfp <= h_fp_i; sh_hsw <= h_sw_i; sh_hbl <= h_blank_i;
            sh_ah0 <= act_h0_i; sh_ah1 <= act_h1_i;
            sh_vfp <= v_fp_i; sh_vsw <= v_sw_i; sh_vbl <= v_blank_i;
            sh_f0fp <= f0_v_fp_i; sh_f0sw <= f0_v_sw_i; sh_f0bl <= f0_v_blank_i;
            sh_frise <= fld_rise_i; sh_ffall <= fld_fall_i; sh_std <= std_i;
            sh_spos <= sof_pos_i; sh_sline <= sof_line_i; sh_div <= div_len_i;
        end
    end

    vtg_hcount #(.HW(HW)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .act_w(sh_aw), .fp(sh_hfp), .sw(sh_hsw), .blank(sh_hbl),
        .h(h), .line_end(line_end), .h_act(h_act), .h_sync(h_sync)
    );

    vtg_vcount #(.VW(VW)) u_vcnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .adv(line_end), .ilace(sh_ilace),
        .a0(sh_ah0), .a1(sh_ah1), .fp(sh_vfp), .sw(sh_vsw), .blank(sh_vbl),
        .f0_fp(sh_f0fp), .f0_sw(sh_f0sw), .f0_blank(sh_f0bl),
        .f_rise(sh_frise), .f_fall(sh_ffall),
        .v(v), .total(v_total), .vs0(v_vs0), .last_line(last_line),
        .v_act(v_act), .v_sync(v_sync), .field(fld)
    );

    vtg_sof #(.HW(HW), .VW(VW)) u_sof (
        .clk(clk), .rst_n(rst_n), .clr(clr), .h(h), .v(v),
        .total(v_total), .vs0(v_vs0), .pos(sh_spos), .line(sh_sline), .sof(sof_w)
    );

    vtg_divider #(.DW(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(clr), .len(sh_div), .tick_now(tick_now)
    );

    // Output registers: live timing while running, idle levels otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 1'b0; vs_q <= 1'b0; de_q <= 1'b0; fld_q <= 1'b0;
            tick_q <= 1'b0; std_q <= '0;
        end else begin
            std_q <= sh_std;
            if (running) begin
                hs_q   <= h_sync ~^ sh_hpol;
                vs_q   <= v_sync ~^ sh_vpol;
                de_q   <= h_act & v_act;
                fld_q  <= fld;
                tick_q <= tick_now;
            end else begin
                hs_q   <= ~sh_hpol;
                vs_q   <= ~sh_vpol;
                de_q   <= 1'b0;
                fld_q  <= 1'b0;
                tick_q <= 1'b0;
            end
        end
    end

    assign hsync_o    = hs_q;
    assign vsync_o    = vs_q;
    assign de_o       = de_q;
    assign field_o    = fld_q;
    assign sof_o      = sof_w;
    assign std_o      = std_q;
    assign div_tick_o = tick_q;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (!de_o && !sof_o && !div_tick_o && !field_o));
endmodule

// File: tb/sim_vtg_raster_gen.sv
// Self-checking bench: directed and seeded random modes. Reference values are
// computed from the requirement formulas. The clock period is 10 units (100 MHz at 1 ns).
module sim_vtg_raster_gen;
    typedef struct {
        int ilace, aw, ah0, ah1, hfp, hsw, hbl, vfp, vsw, vbl, f0fp, f0sw, f0bl;
        int frise, ffall, std, ssamp, ssub, sline, div, hpol, vpol;
    } mode_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic valid = 1'b0;
    mode_t drv, cur;
    int nchk = 0, nfail = 0;
    int bh, bv, g;
    bit hist[8];

    logic hs, vs, de, fld, sof, tick;
    logic [7:0] stdv;

    always #5 clk = ~clk;

    vtg_raster_gen u0 (
        .clk(clk), .rst_n(rst_n), .run_i(run), .mode_valid_i(valid),
        .ilace_i(drv.ilace[0]), .act_w_i(12'(drv.aw)), .act_h0_i(11'(drv.ah0)),
        .act_h1_i(11'(drv.ah1)), .h_fp_i(12'(drv.hfp)), .h_sw_i(12'(drv.hsw)),
        .h_blank_i(12'(drv.hbl)), .v_fp_i(11'(drv.vfp)), .v_sw_i(11'(drv.vsw)),
        .v_blank_i(11'(drv.vbl)), .f0_v_fp_i(11'(drv.f0fp)), .f0_v_sw_i(11'(drv.f0sw)),
        .f0_v_blank_i(11'(drv.f0bl)), .fld_rise_i(11'(drv.frise)),
        .fld_fall_i(11'(drv.ffall)), .hs_pol_i(drv.hpol[0]), .vs_pol_i(drv.vpol[0]),
        .std_i(8'(drv.std)), .sof_pos_i(16'((drv.ssamp << 2) | drv.ssub)),
        .sof_line_i(13'(drv.sline)), .div_len_i(14'(drv.div)),
        .hsync_o(hs), .vsync_o(vs), .de_o(de), .field_o(fld), .sof_o(sof),
        .std_o(stdv), .div_tick_o(tick)
    );

    function automatic int htot(mode_t m); return m.aw + m.hbl; endfunction
    function automatic int vtot(mode_t m);
        return m.ilace ? (m.ah0 + m.f0bl + m.ah1 + m.vbl) : (m.ah0 + m.vbl);
    endfunction
    function automatic int vs0_line(mode_t m);
        return m.ah0 + (m.ilace ? m.f0fp : m.vfp);
    endfunction
    function automatic bit line_active(mode_t m, int l);
        int b1;
        b1 = m.ah0 + m.f0bl;
        if (l < m.ah0) return 1;
        return m.ilace != 0 && l >= b1 && l < b1 + m.ah1;
    endfunction
    function automatic bit line_sync(mode_t m, int l);
        int s1;
        s1 = m.ah0 + m.f0bl + m.ah1 + m.vfp;
        if (l >= vs0_line(m) && l < vs0_line(m) + (m.ilace ? m.f0sw : m.vsw)) return 1;
        return m.ilace != 0 && l >= s1 && l < s1 + m.vsw;
    endfunction
    function automatic bit field_at(mode_t m, int l);
        if (m.ilace == 0) return 0;
        if (m.frise <= m.ffall) return l >= m.frise && l < m.ffall;
        return l >= m.frise || l < m.ffall;
    endfunction

    task automatic chk(string req, string nm, int got, int exp);
        nchk++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d (pos %0d,%0d)", req, nm, got, exp, bh, bv);
        end
    endtask

    // Check one raster sample against the model, then advance to the next.
    task automatic step();
        bit hsa, eh;
        int d;
        hsa = bh >= cur.aw + cur.hfp && bh < cur.aw + cur.hfp + cur.hsw;
        hist[g % 8] = (bh == cur.ssamp) && (bv == (vs0_line(cur) + cur.sline) % vtot(cur));
        eh = (g >= cur.ssub) ? hist[(g - cur.ssub) % 8] : 1'b0;
        d = (cur.div < 1) ? 1 : cur.div;
        chk("R2/R5", "hsync", int'(hs), cur.hpol ? int'(hsa) : int'(!hsa));
        chk("R3/R4", "vsync", int'(vs), cur.vpol ? int'(line_sync(cur, bv)) : int'(!line_sync(cur, bv)));
        chk("R2", "de", int'(de), int'(bh < cur.aw && line_active(cur, bv)));
        chk("R6", "field", int'(fld), int'(field_at(cur, bv)));
        chk("R7/R8", "sof", int'(sof), int'(eh));
        chk("R9", "tick", int'(tick), int'((g % d) == d - 1));
        chk("R10", "std", int'(stdv), cur.std);
        g++; bh++;
        if (bh >= htot(cur)) begin
            bh = 0; bv++;
            if (bv >= vtot(cur)) begin bv = 0; cur = drv; end
        end
        @(negedge clk);
    endtask

    task automatic check_idle(string req, int n);
        for (int i = 0; i < n; i++) begin
            chk(req, "idle hsync", int'(hs), int'(!drv.hpol[0]));
            chk(req, "idle vsync", int'(vs), int'(!drv.vpol[0]));
            chk(req, "idle de/field/sof/tick", int'({de, fld, sof, tick}), 0);
            @(negedge clk);
        end
    endtask

    // R12: position 0 appears after the second edge with run and valid high.
    task automatic start_run();
        run = 1'b1; valid = 1'b1;
        @(negedge clk); @(negedge clk);
        cur = drv; bh = 0; bv = 0; g = 0;
        for (int i = 0; i < 8; i++) hist[i] = 0;
    endtask

    // R12/R13: one more live position after the drop, then idle.
    task automatic stop_run(bit by_valid, string req);
        if (by_valid) valid = 1'b0; else run = 1'b0;
        step(); step();
        check_idle(req, 5);
        run = 1'b0; valid = 1'b0;
    endtask

    task automatic run_frames(int nf);
        for (int i = 0; i < nf * htot(cur) * vtot(cur); i++) step();
    endtask

    function automatic mode_t gen_mode();
        mode_t m;
        int vt;
        m.aw = $urandom_range(1, 8); m.hfp = $urandom_range(0, 2); m.hsw = $urandom_range(1, 3);
        m.hbl = m.hfp + m.hsw + $urandom_range(0, 2);
        m.ah0 = $urandom_range(1, 5); m.ah1 = $urandom_range(1, 5);
        m.vfp = $urandom_range(0, 2); m.vsw = $urandom_range(1, 2);
        m.vbl = m.vfp + m.vsw + $urandom_range(0, 2);
        m.f0fp = $urandom_range(0, 2); m.f0sw = $urandom_range(1, 2);
        m.f0bl = m.f0fp + m.f0sw + $urandom_range(0, 2);
        m.ilace = $urandom_range(0, 1);
        vt = vtot(m);
        m.frise = $urandom_range(0, vt - 1); m.ffall = $urandom_range(0, vt - 1);
        m.std = $urandom_range(0, 255);
        m.ssamp = $urandom_range(0, htot(m) - 1); m.ssub = $urandom_range(0, 3);
        m.sline = $urandom_range(0, vt - 1); m.div = $urandom_range(1, 9);
        m.hpol = $urandom_range(0, 1); m.vpol = $urandom_range(0, 1);
        return m;
    endfunction

    initial begin
        #1_500_000;
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        mode_t b;
        void'($urandom(32'd1234));
        // Directed progressive mode: 11 x 8 raster.
        drv = '{ilace:0, aw:6, ah0:4, ah1:2, hfp:1, hsw:2, hbl:5, vfp:1, vsw:2, vbl:4,
                f0fp:0, f0sw:1, f0bl:2, frise:2, ffall:5, std:'h5A, ssamp:3, ssub:0,
                sline:1, div:5, hpol:1, vpol:0};
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset outputs", int'({hs, vs, de, fld, sof, tick}), 0);
        chk("R1", "reset std", int'(stdv), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("R1", 4);
        start_run();
        run_frames(2);
        stop_run(1'b0, "R12");
        // Directed interlaced mode: wrapping field flag, sof on the last sample with delay 3, div 1.
        drv = '{ilace:1, aw:5, ah0:3, ah1:4, hfp:0, hsw:1, hbl:3, vfp:0, vsw:2, vbl:3,
                f0fp:1, f0sw:1, f0bl:3, frise:11, ffall:2, std:'hC3, ssamp:7, ssub:3,
                sline:12, div:1, hpol:0, vpol:1};
        @(negedge clk); @(negedge clk);
        start_run();
        run_frames(3);
        stop_run(1'b0, "R12");
        // R13: valid gating with run held high
        drv = gen_mode();
        @(negedge clk); @(negedge clk);
        run = 1'b1;
        check_idle("R13", 10);
        start_run();
        run_frames(1);
        stop_run(1'b1, "R13");
        // R11: rewrite the mode mid-frame; the new one starts at the frame end
        drv = gen_mode();
        @(negedge clk); @(negedge clk);
        start_run();
        for (int i = 0; i < (htot(cur) * vtot(cur)) / 2; i++) step();
        b = gen_mode();
        b.ssub = drv.ssub; b.div = drv.div;
        drv = b;
        while (!(bh == 0 && bv == 0)) step();
        chk("R11", "new std at frame start", int'(stdv), b.std);
        run_frames(2);
        stop_run(1'b0, "R12");
        // Seeded random modes
        for (int k = 0; k < 16; k++) begin
            drv = gen_mode();
            @(negedge clk); @(negedge clk);
            start_run();
            run_frames(2);
            stop_run(k[0], "R12");
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule